// File: doc/BRIEF.md
# Dual-Mode Serial Register Port

This block is a slave control port that gives an external host access to an 8-bit register file. It can use either a write-only four-wire serial link (chip select, clock, data in) or a two-wire bus with an open-drain data line. Both protocols share one set of pins, so the port decides after reset which one is in use. The first falling edge on the shared select/strap pin switches the port to the four-wire protocol for good. Until that edge is seen, the port speaks the two-wire protocol, and the same pin is read as the low bit of the bus address.

Every transfer opens with a chip-address byte. A pointer byte follows: its low seven bits name a register, and its top bit picks auto-increment. Data bytes come after that. Two-wire reads use the pointer left by an earlier write that stopped right after the pointer byte. Register 01h is a read-only identity byte that the port supplies itself. Bit 7 of register 02h is replaced on reads by a live unlock status input. The register file lives outside the port and is reached through a simple write strobe and a combinational read path.

Top module: `ctlport_top`

## Requirements
- R1: After reset, `sda_oe_o`, `reg_we_o` and `spi_mode_o` are all 0.
- R2: `spi_mode_o` goes to 1 after the first falling edge on `cs_ad0_i` following reset. It then stays at 1 until the next reset. With no such edge, the port answers only the two-wire protocol.
- R3: In four-wire mode, each frame is one CS-low period, and bits are sampled on rising CCLK, MSB first. A frame whose first byte is 9Eh, then a pointer byte, then data bytes, writes each data byte through `reg_we_o` at the current pointer.
- R4: In four-wire mode, a frame whose first byte is not 9Eh causes no write for the rest of that frame. The next frame is decoded normally.
- R5: In two-wire mode, an address byte whose upper seven bits are 100111 followed by the current `cs_ad0_i` level is acknowledged by pulling SDA low in the ninth clock. Bit 0 of that byte is 1 for a read. Any other address is not acknowledged, and SDA is not driven until the next START or STOP.
- R6: In the pointer byte, bits 6:0 give the register address and bit 7 is the increment flag. With the flag at 1, the pointer advances by one after each data byte written or read. With the flag at 0, all data bytes go to the same address.
- R7: In two-wire write transfers, the address, pointer and data bytes are each acknowledged, and each data byte is written at the pointer.
- R8: A two-wire read returns the byte at the pointer set by the last pointer byte, MSB first. A master acknowledge asks for the next byte (advanced if the increment flag is set). A master non-acknowledge ends the read, and the port then drives nothing until STOP or START.
- R9: Reading address 01h returns 00000 in bits 7:3 and the parameter `REVISION` in bits 2:0. A write to 01h never raises `reg_we_o`.
- R10: Reading address 02h returns `unlock_i` in bit 7 and bits 6:0 of the register file.
- R11: A START or STOP on the two-wire bus, or CS rising on the four-wire link, in the middle of a byte throws the partial byte away without a write. After a START, the next byte is taken as a new address byte.
- R12: In four-wire mode, `sda_oe_o` is never asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_ad0_i | input | 1 | Four-wire chip select, or two-wire address strap |
| scl_i | input | 1 | Serial clock for either protocol |
| sda_i | input | 1 | Serial data in (two-wire SDA level or four-wire CDIN) |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| unlock_i | input | 1 | Live unlock status, returned in bit 7 of register 02h |
| reg_rdata_i | input | 8 | Register file read data for `reg_addr_o` |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_addr_o | output | 7 | Register address: the write address while `reg_we_o` is 1, otherwise the pointer |
| reg_wdata_o | output | 8 | Register write data |
| spi_mode_o | output | 1 | 1 once four-wire mode is latched |

## Verification
The pointer logic is exercised with the increment flag set and cleared. Two-byte bursts show apart an advancing pointer and a fixed one, by whether the second byte lands beside the first or on top of it. Reads are run after a pointer-only write, with a master acknowledge and then a non-acknowledge, so that a wrong bit order, an increment missing at the acknowledge, or a stale pointer each give a different byte. Address decoding is tried with matching and non-matching strap bits and a wrong four-wire chip byte, and each mismatch has to leave both the register file and SDA untouched. Transfers cut off by START, STOP or CS rising in the middle of a byte confirm that partial bytes are dropped and that the next transfer still decodes.

// File: rtl/ctlport_pkg.sv
// Shared constants and state encoding for the dual-mode serial register port.
// Assumes 8-bit registers and a 7-bit register address taken from the pointer byte.
package ctlport_pkg;
    localparam int DATA_W = 8;
    localparam int PTR_W  = 7;
    localparam int CNT_W  = 4;

    // Fixed four-wire chip byte and upper six bits of the two-wire address.
    localparam logic [DATA_W-1:0] SPI_CHIP_BYTE = 8'h9E;
    localparam logic [5:0]        BUS_ADDR_HI   = 6'b100111;

    // Register addresses served partly by the port itself.
    localparam logic [PTR_W-1:0]  ID_ADDR     = 7'h01;
    localparam logic [PTR_W-1:0]  STATUS_ADDR = 7'h02;

    typedef enum logic [2:0] {
        P_IDLE,
        P_CHIP,
        P_PTR,
        P_WR,
        P_RD,
        P_SKIP
    } port_state_t;
endpackage

// File: rtl/ctlport_sync.sv
// Multi-stage synchronizer for asynchronous pin inputs.
// Assumes each bit is a slow level signal. Reset value is per bit, so idle levels give no false edge.
module ctlport_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe [STAGES];

    // Shift pin levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d_i;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/ctlport_events.sv
// Turns synchronized pin levels into protocol events and latches the protocol mode.
// Assumes all inputs come through equal-depth synchronizers, so their relative order is kept.
module ctlport_events (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s_i,
    input  logic scl_s_i,
    input  logic sda_s_i,
    output logic spi_mode_o,
    output logic frame_start_o,
    output logic frame_end_o,
    output logic bit_rise_o,
    output logic bit_fall_o
);
    logic cs_q, scl_q, sda_q, spi_q;
    logic cs_fall, cs_rise, scl_rise, scl_fall, bus_start, bus_stop, spi_eff;

    // Remember the previous synchronized levels and the sticky mode bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
            spi_q <= 1'b0;
        end else begin
            cs_q  <= cs_s_i;
            scl_q <= scl_s_i;
            sda_q <= sda_s_i;
            if (cs_fall) spi_q <= 1'b1;
        end
    end

    // Edge and bus-condition decoding, steered by the mode.
    always_comb begin
        cs_fall   = cs_q & ~cs_s_i;
        cs_rise   = ~cs_q & cs_s_i;
        scl_rise  = ~scl_q & scl_s_i;
        scl_fall  = scl_q & ~scl_s_i;
        bus_start = scl_q & scl_s_i & sda_q & ~sda_s_i;
        bus_stop  = scl_q & scl_s_i & ~sda_q & sda_s_i;
        spi_eff   = spi_q | cs_fall;
        frame_start_o = spi_eff ? cs_fall : bus_start;
        frame_end_o   = spi_eff ? cs_rise : bus_stop;
        bit_rise_o    = spi_eff ? (scl_rise & ~cs_s_i) : scl_rise;
        bit_fall_o    = ~spi_eff & scl_fall;
    end

    assign spi_mode_o = spi_q;
endmodule

// File: rtl/ctlport_engine.sv
// Byte framing, address decode, pointer handling and SDA driving for both protocols.
// Assumes one event per cycle from ctlport_events, and a combinational read byte for ptr_o.
module ctlport_engine
    import ctlport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_mode_i,
    input  logic              frame_start_i,
    input  logic              frame_end_i,
    input  logic              bit_rise_i,
    input  logic              bit_fall_i,
    input  logic              sda_s_i,
    input  logic              ad0_i,
    input  logic [DATA_W-1:0] rd_byte_i,
    output logic [PTR_W-1:0]  ptr_o,
    output logic              wr_en_o,
    output logic [PTR_W-1:0]  wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              sda_oe_o
);
    port_state_t        state, nxt_q, next_s;
    logic [CNT_W-1:0]   bitcnt;
    logic [DATA_W-2:0]  shreg;
    logic [DATA_W-2:0]  tx;
    logic [PTR_W-1:0]   ptr;
    logic               incr;
    logic [DATA_W-1:0]  byte_in;
    logic               byte_ok;
    logic               rx_state;
    logic [PTR_W-1:0]   ptr_step;

    // Decode the byte being completed and choose where the transfer goes next.
    always_comb begin
        byte_in  = {shreg, sda_s_i};
        rx_state = (state == P_CHIP) || (state == P_PTR) || (state == P_WR);
        ptr_step = ptr + {{(PTR_W-1){1'b0}}, incr};
        byte_ok  = 1'b1;
        next_s   = P_WR;
        if (state == P_CHIP) begin
            byte_ok = spi_mode_i ? (byte_in == SPI_CHIP_BYTE)
                                 : (byte_in[7:1] == {BUS_ADDR_HI, ad0_i});
            next_s  = (!spi_mode_i && byte_in[0]) ? P_RD : P_PTR;
        end
    end

    // Protocol sequencer: shift bits, acknowledge, write, and serve reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= P_IDLE;
            nxt_q     <= P_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            tx        <= '0;
            ptr       <= '0;
            incr      <= 1'b0;
            sda_oe_o  <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            wr_en_o <= 1'b0;
            if (frame_start_i) begin
                state    <= P_CHIP;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (frame_end_i) begin
                state    <= P_IDLE;
                bitcnt   <= '0;
                sda_oe_o <= 1'b0;
            end else if (bit_rise_i) begin
                if (rx_state && bitcnt < 4'd8) begin
                    shreg <= byte_in[DATA_W-2:0];
                    if (bitcnt == 4'd7) begin
                        if (!byte_ok) begin
                            state  <= P_SKIP;
                            bitcnt <= '0;
                        end else begin
                            if (state == P_PTR) begin
                                ptr  <= byte_in[PTR_W-1:0];
                                incr <= byte_in[DATA_W-1];
                            end
                            if (state == P_WR) begin
                                if (ptr != ID_ADDR) begin
                                    wr_en_o   <= 1'b1;
                                    wr_addr_o <= ptr;
                                    wr_data_o <= byte_in;
                                end
                                ptr <= ptr_step;
                            end
                            if (spi_mode_i) begin
                                state  <= next_s;
                                bitcnt <= '0;
                            end else begin
                                nxt_q  <= next_s;
                                bitcnt <= 4'd8;
                            end
                        end
                    end else begin
                        bitcnt <= bitcnt + 4'd1;
                    end
                end else if (state == P_RD) begin
                    if (bitcnt < 4'd8) begin
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd9) begin
                        if (!sda_s_i) begin
                            ptr    <= ptr_step;
                            bitcnt <= 4'd10;
                        end else begin
                            state  <= P_SKIP;
                            bitcnt <= '0;
                        end
                    end
                end
            end else if (bit_fall_i) begin
                if (rx_state && bitcnt == 4'd8) begin
                    sda_oe_o <= 1'b1;
                    bitcnt   <= 4'd9;
                end else if (rx_state && bitcnt == 4'd9) begin
                    sda_oe_o <= 1'b0;
                    bitcnt   <= '0;
                    state    <= nxt_q;
                    if (nxt_q == P_RD) begin
                        tx       <= rd_byte_i[DATA_W-2:0];
                        sda_oe_o <= ~rd_byte_i[DATA_W-1];
                    end
                end else if (state == P_RD) begin
                    if (bitcnt >= 4'd1 && bitcnt <= 4'd7) begin
                        tx       <= {tx[DATA_W-3:0], 1'b0};
                        sda_oe_o <= ~tx[DATA_W-2];
                    end else if (bitcnt == 4'd8) begin
                        sda_oe_o <= 1'b0;
                        bitcnt   <= 4'd9;
                    end else if (bitcnt == 4'd10) begin
                        tx       <= rd_byte_i[DATA_W-2:0];
                        sda_oe_o <= ~rd_byte_i[DATA_W-1];
                        bitcnt   <= '0;
                    end
                end
            end
        end
    end

    assign ptr_o = ptr;
endmodule

// File: rtl/ctlport_top.sv
// Dual-mode serial register port: pin synchronization, event decoding, sequencing and the read mux.
// Assumes an external register file with a combinational read of reg_addr_o.
module ctlport_top
    import ctlport_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [2:0] REVISION    = 3'd4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_ad0_i,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              unlock_i,
    input  logic [DATA_W-1:0] reg_rdata_i,
    output logic              reg_we_o,
    output logic [PTR_W-1:0]  reg_addr_o,
    output logic [DATA_W-1:0] reg_wdata_o,
    output logic              spi_mode_o
);
    localparam logic [DATA_W-1:0] ID_BYTE = {5'b00000, REVISION};

    logic [2:0]        pins_s;
    logic              frame_start, frame_end, bit_rise, bit_fall;
    logic [PTR_W-1:0]  ptr, wr_addr;
    logic [DATA_W-1:0] rd_byte;
    logic              wr_en;

    ctlport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_ad0_i, scl_i, sda_i}),
        .q_o   (pins_s)
    );

    ctlport_events u_events (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_s_i        (pins_s[2]),
        .scl_s_i       (pins_s[1]),
        .sda_s_i       (pins_s[0]),
        .spi_mode_o    (spi_mode_o),
        .frame_start_o (frame_start),
        .frame_end_o   (frame_end),
        .bit_rise_o    (bit_rise),
        .bit_fall_o    (bit_fall)
    );

    // Read byte: identity register, live status bit, or register file.
    always_comb begin
        if (ptr == ID_ADDR)          rd_byte = ID_BYTE;
        else if (ptr == STATUS_ADDR) rd_byte = {unlock_i, reg_rdata_i[DATA_W-2:0]};
        else                         rd_byte = reg_rdata_i;
    end

    ctlport_engine u_engine (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_mode_i    (spi_mode_o),
        .frame_start_i (frame_start),
        .frame_end_i   (frame_end),
        .bit_rise_i    (bit_rise),
        .bit_fall_i    (bit_fall),
        .sda_s_i       (pins_s[0]),
        .ad0_i         (pins_s[2]),
        .rd_byte_i     (rd_byte),
        .ptr_o         (ptr),
        .wr_en_o       (wr_en),
        .wr_addr_o     (wr_addr),
        .wr_data_o     (reg_wdata_o),
        .sda_oe_o      (sda_oe_o)
    );

    assign reg_we_o   = wr_en;
    assign reg_addr_o = wr_en ? wr_addr : ptr;
endmodule

// File: rtl/ctlport_checker.sv
// Temporal checks on the port's outputs, bound into ctlport_top.
// Assumes scl_i is driven by a master that holds SCL low while the slave changes SDA.
module ctlport_checker
    import ctlport_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_i,
    input logic             sda_oe_o,
    input logic             spi_mode_o,
    input logic             reg_we_o,
    input logic [PTR_W-1:0] reg_addr_o
);
    // R12: the four-wire link never drives the data pad.
    assert_spi_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_o |-> !sda_oe_o);

    // R2: once latched, the mode holds until reset.
    assert_mode_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        spi_mode_o |=> spi_mode_o);

    // R9: the identity address is never written.
    assert_no_id_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (reg_addr_o != ID_ADDR));

    // R3: each completed byte gives a single-cycle strobe.
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |=> !reg_we_o);

    // R7: SDA drive only begins while the clock is low.
    assert_drive_in_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);
endmodule

bind ctlport_top ctlport_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .spi_mode_o (spi_mode_o),
    .reg_we_o   (reg_we_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/ctlport_top_tb.sv
`timescale 1ns/1ps
// Directed bench for ctlport_top: one task per scenario, each checking its own results.
module ctlport_top_tb;
    localparam int HP = 10;
    localparam logic [2:0] REV = 3'd4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_pin = 1'b1;
    logic       scl = 1'b1;
    logic       m_pull = 1'b0;
    logic       unlock = 1'b0;
    logic       tb_clr = 1'b1;
    logic       sda_line;
    logic       sda_oe_o, reg_we_o, spi_mode_o;
    logic [6:0] reg_addr_o;
    logic [7:0] reg_wdata_o, reg_rdata_i;
    logic [7:0] mem [0:127];
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;
    bit         spi_oe_seen = 1'b0;

    always #4 clk = ~clk;

    assign sda_line    = ~(m_pull | sda_oe_o);
    assign reg_rdata_i = mem[reg_addr_o];

    ctlport_top #(.REVISION(REV)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_ad0_i    (cs_pin),
        .scl_i       (scl),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe_o),
        .unlock_i    (unlock),
        .reg_rdata_i (reg_rdata_i),
        .reg_we_o    (reg_we_o),
        .reg_addr_o  (reg_addr_o),
        .reg_wdata_o (reg_wdata_o),
        .spi_mode_o  (spi_mode_o)
    );

    // Bench-side register file, filled only through the write port.
    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 128; i++) mem[i] <= 8'h00;
        end else if (reg_we_o) begin
            mem[reg_addr_o] <= reg_wdata_o;
        end
    end

    // Record any pad drive while in four-wire mode.
    always @(negedge clk) if (spi_mode_o && sda_oe_o) spi_oe_seen <= 1'b1;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic i2c_start();
        m_pull = 1'b0; wait_cyc(2);
        scl = 1'b1;    wait_cyc(HP);
        m_pull = 1'b1; wait_cyc(HP);
        scl = 1'b0;    wait_cyc(HP);
    endtask

    task automatic i2c_stop();
        m_pull = 1'b1; wait_cyc(2);
        scl = 1'b1;    wait_cyc(HP);
        m_pull = 1'b0; wait_cyc(HP);
    endtask

    task automatic i2c_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_pull = ~b[i]; wait_cyc(HP);
            scl = 1'b1;     wait_cyc(HP);
            scl = 1'b0;     wait_cyc(2);
        end
    endtask

    task automatic i2c_wbyte(input logic [7:0] b, output logic ack);
        i2c_bits(b, 8);
        m_pull = 1'b0; wait_cyc(HP);
        scl = 1'b1;    wait_cyc(HP/2);
        ack = ~sda_line;
        wait_cyc(HP/2);
        scl = 1'b0;    wait_cyc(2);
    endtask

    task automatic i2c_rbyte(input logic mack, output logic [7:0] b);
        m_pull = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_cyc(HP);
            scl = 1'b1; wait_cyc(HP/2);
            b[i] = sda_line;
            wait_cyc(HP/2);
            scl = 1'b0; wait_cyc(2);
        end
        m_pull = mack; wait_cyc(HP);
        scl = 1'b1;    wait_cyc(HP);
        scl = 1'b0;    wait_cyc(2);
        m_pull = 1'b0;
    endtask

    // Full write: address, pointer, two data bytes; returns AND of acks.
    task automatic i2c_write2(input logic ad0, input logic [7:0] p,
                              input logic [7:0] d0, input logic [7:0] d1, output logic all_ack);
        logic a0, a1, a2, a3;
        i2c_start();
        i2c_wbyte({6'b100111, ad0, 1'b0}, a0);
        i2c_wbyte(p, a1);
        i2c_wbyte(d0, a2);
        i2c_wbyte(d1, a3);
        i2c_stop();
        all_ack = a0 & a1 & a2 & a3;
    endtask

    // Pointer-only write stopped after the pointer byte.
    task automatic i2c_set_ptr(input logic [7:0] p, output logic all_ack);
        logic a0, a1;
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b0}, a0);
        i2c_wbyte(p, a1);
        i2c_stop();
        all_ack = a0 & a1;
    endtask

    task automatic i2c_read1(output logic [7:0] d, output logic ack);
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b1}, ack);
        i2c_rbyte(1'b0, d);
        i2c_stop();
    endtask

    task automatic spi_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_pull = ~b[i]; wait_cyc(HP);
            scl = 1'b1;     wait_cyc(HP);
            scl = 1'b0;     wait_cyc(2);
        end
    endtask

    task automatic spi_frame3(input logic [7:0] c, input logic [7:0] p,
                              input logic [7:0] d0, input logic [7:0] d1);
        cs_pin = 1'b0; wait_cyc(HP);
        spi_bits(c, 8);
        spi_bits(p, 8);
        spi_bits(d0, 8);
        spi_bits(d1, 8);
        cs_pin = 1'b1; wait_cyc(HP);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1 sda_oe after reset", sda_oe_o, 1'b0);
        chk("R1 reg_we after reset", reg_we_o, 1'b0);
        chk("R1 spi_mode after reset", spi_mode_o, 1'b0);
    endtask

    task automatic t_i2c_write_incr();
        logic ok;
        i2c_write2(1'b1, 8'h90, 8'hA5, 8'h3C, ok);
        chk("R5 R7 acks on matching write", ok, 1'b1);
        chk("R7 first byte at 10h", mem[7'h10], 8'hA5);
        chk("R6 incremented byte at 11h", mem[7'h11], 8'h3C);
    endtask

    task automatic t_i2c_write_fixed();
        logic ok;
        i2c_write2(1'b1, 8'h20, 8'h11, 8'h22, ok);
        chk("R6 fixed pointer last byte at 20h", mem[7'h20], 8'h22);
        chk("R6 fixed pointer leaves 21h", mem[7'h21], 8'h00);
    endtask

    task automatic t_i2c_read();
        logic ok, a;
        logic [7:0] d0, d1;
        i2c_set_ptr(8'h90, ok);
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b1}, a);
        i2c_rbyte(1'b1, d0);
        i2c_rbyte(1'b0, d1);
        chk("R8 port idle after nack", sda_oe_o, 1'b0);
        i2c_stop();
        chk("R8 read address ack", a & ok, 1'b1);
        chk("R8 first read byte", d0, 8'hA5);
        chk("R8 second read byte after ack", d1, 8'h3C);
    endtask

    task automatic t_wrong_addr();
        logic a0, a1;
        i2c_start();
        i2c_wbyte({6'b100111, 1'b0, 1'b0}, a0);
        i2c_wbyte(8'h48, a1);
        i2c_wbyte(8'h5A, a1);
        i2c_stop();
        chk("R5 mismatched address not acked", a0, 1'b0);
        chk("R5 later bytes not acked", a1, 1'b0);
        chk("R5 no write after mismatch", mem[7'h48], 8'h00);
    endtask

    task automatic t_id_reg();
        logic ok, a;
        logic [7:0] d;
        i2c_write2(1'b1, 8'h01, 8'hFF, 8'hEE, ok);
        chk("R9 identity register not written", mem[7'h01], 8'h00);
        i2c_set_ptr(8'h01, ok);
        i2c_read1(d, a);
        chk("R9 identity read value", d, {5'b00000, REV});
    endtask

    task automatic t_unlock();
        logic ok, a;
        logic [7:0] d;
        i2c_write2(1'b1, 8'h02, 8'h15, 8'h15, ok);
        unlock = 1'b1;
        i2c_set_ptr(8'h02, ok);
        i2c_read1(d, a);
        chk("R10 status read with unlock high", d, 8'h95);
        unlock = 1'b0;
        i2c_read1(d, a);
        chk("R10 status read with unlock low", d, 8'h15);
    endtask

    task automatic t_abort();
        logic a0, a1, ok;
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b0}, a0);
        i2c_wbyte(8'h30, a1);
        i2c_bits(8'hC3, 4);
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b0}, a0);
        i2c_wbyte(8'h31, a1);
        i2c_wbyte(8'h6B, ok);
        i2c_stop();
        chk("R11 partial byte before START dropped", mem[7'h30], 8'h00);
        chk("R11 transfer after START decoded", mem[7'h31], 8'h6B);
        i2c_start();
        i2c_wbyte({6'b100111, 1'b1, 1'b0}, a0);
        i2c_wbyte(8'h32, a1);
        i2c_bits(8'h99, 5);
        i2c_stop();
        chk("R11 partial byte before STOP dropped", mem[7'h32], 8'h00);
    endtask

    task automatic t_ad0_low();
        logic ok;
        cs_pin = 1'b0;
        do_reset();
        chk("R2 low strap gives no mode change", spi_mode_o, 1'b0);
        i2c_write2(1'b0, 8'h40, 8'h77, 8'h77, ok);
        chk("R5 strap low address acked", ok, 1'b1);
        chk("R7 write with strap low", mem[7'h40], 8'h77);
    endtask

    task automatic t_spi();
        scl = 1'b0;
        cs_pin = 1'b1;
        wait_cyc(HP);
        spi_frame3(8'h9E, 8'hC4, 8'h01, 8'h02);
        chk("R2 four-wire mode latched", spi_mode_o, 1'b1);
        chk("R3 four-wire write at 44h", mem[7'h44], 8'h01);
        chk("R3 four-wire write at 45h", mem[7'h45], 8'h02);
        spi_frame3(8'h9C, 8'h80 | 8'h50, 8'hEE, 8'hEE);
        chk("R4 wrong chip byte writes nothing", mem[7'h50], 8'h00);
        spi_frame3(8'h9E, 8'h05, 8'h10, 8'h20);
        chk("R6 four-wire fixed pointer", mem[7'h05], 8'h20);
        chk("R6 four-wire fixed pointer leaves 06h", mem[7'h06], 8'h00);
        spi_frame3(8'h9E, 8'h01, 8'h55, 8'h55);
        chk("R9 four-wire write to identity dropped", mem[7'h01], 8'h00);
        cs_pin = 1'b0; wait_cyc(HP);
        spi_bits(8'h9E, 8);
        spi_bits(8'h60, 8);
        spi_bits(8'hF0, 4);
        cs_pin = 1'b1; wait_cyc(HP);
        chk("R11 CS rise drops partial byte", mem[7'h60], 8'h00);
        chk("R12 no pad drive in four-wire mode", spi_oe_seen, 1'b0);
        chk("R2 mode still latched", spi_mode_o, 1'b1);
    endtask

    initial begin
        wait_cyc(3);
        tb_clr = 1'b0;
        do_reset();
        t_reset();
        t_i2c_write_incr();
        t_i2c_write_fixed();
        t_i2c_read();
        t_wrong_addr();
        t_id_reg();
        t_unlock();
        t_abort();
        chk("R2 two-wire traffic keeps mode", spi_mode_o, 1'b0);
        t_ad0_low();
        t_spi();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual 150000 cycles expected completion earlier");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule